// File: doc/BRIEF.md
# Dual-Line Serial Flash Command Front-End

This block is the target-side protocol engine of a serial flash device running in its two-line mode. Every phase of a transaction moves two bits per serial clock on two data lines: the 8-bit opcode, the 24-bit address, and the returned data. The engine decodes the opcode from the first four clocks. For a dual fast read, it collects the address, waits a configurable number of dummy clocks, and then streams array bytes from a memory read port with an incrementing address until the host deselects. For the multi-line identification command, it returns the three standard identification bytes with no address and no dummy phase. Opcodes that this mode does not support are ignored, and the data lines are never driven for them.

The block runs on a fast system clock. Chip select, the serial clock and the incoming data lines are assumed to be already synchronous to that clock. The serial clock is oversampled, and its edges are found internally. Data is sampled on rising serial-clock edges and launched after falling edges. The memory port is an asynchronous read: `mem_data` must reflect `mem_addr` within the same system cycle. The dummy count comes from a field of either the volatile or the non-volatile configuration register. After each deselect, a flag reports whether the host may reselect after the shortened post-read gap or must use the normal gap.

Top module: `dspi_flash_frontend`

## Requirements
- R1: Each serial clock carries one bit pair. `dq_i[1]`/`dq_o[1]` holds the higher bit of the pair and bit 0 the lower bit, and the most significant pair comes first. Inputs are taken on the rising serial-clock edge and outputs change only after a falling edge. The opcode takes 4 clocks and the 24-bit address takes 12 clocks.
- R2: Opcodes BBh, 3Bh and 0Bh each start the same dual fast read: opcode, then address, then dummy clocks, then data.
- R3: The dummy clock count is taken from `vol_cfg[7:4]` when `dummy_src_nv` is 0, and from `nv_cfg[15:12]` when it is 1. The source is sampled when the opcode is decoded.
- R4: A dummy field value of 0 selects `DEF_DUMMY` clocks (8 by default). The values 1 to 15 give that many clocks.
- R5: `dq_oe` is always 00 or 11. It stays 00 through the opcode, address and dummy phases and becomes 11 from the falling edge that follows the last dummy clock.
- R6: A fast read returns `mem_data` for the captured address first. It then moves on to the next address for every further byte, wrapping from FFFFFFh to 000000h, until deselect.
- R7: Opcode AFh returns exactly the three bytes `ID_BYTE0`, `ID_BYTE1`, `ID_BYTE2`, starting right after the opcode with no address or dummy phase. After the third byte both lines are released for the rest of the select.
- R8: The unsupported opcodes 03h, 6Bh, EBh, 02h and 9Fh, and any other opcode not listed in R2 or R7, are ignored. `dq_oe` stays 00 until deselect.
- R9: `cs_n` high returns the engine to the opcode phase and releases both lines by the next system clock, from any phase. The next select starts a fresh command.
- R10: `fast_reselect` is 0 after reset. It is updated on each deselect: it becomes 1 if the select that just ended drove at least one complete byte of a fast read or identification read, and 0 otherwise. It holds its value between deselects.
- R11: `hold_en` is the inverse of `enh_cfg[4]`, so a 1 in that bit disables the hold/reset function.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial interface |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock from the host |
| dq_i | input | 2 | Incoming data lines, bit 1 is the higher bit of a pair |
| dq_o | output | 2 | Outgoing data lines |
| dq_oe | output | 2 | Output enables for the two data lines |
| mem_addr | output | ADDR_W | Array read address |
| mem_data | input | 8 | Array read data for `mem_addr` |
| vol_cfg | input | 4 | Volatile configuration bits [7:4], dummy field |
| nv_cfg | input | 4 | Non-volatile configuration bits [15:12], dummy field |
| dummy_src_nv | input | 1 | 1 selects the non-volatile dummy field |
| enh_cfg | input | 1 | Enhanced volatile configuration bit 4, hold/reset disable |
| hold_en | output | 1 | Hold/reset function enabled |
| fast_reselect | output | 1 | Shortened deselect gap allowed after the last select |

## Verification
The fast read is run with each of its three opcodes and with several address patterns, including one that wraps at the top of the address space. Because the bench memory model mixes all three address bytes, an error in pair order or address shifting shows up as wrong data. The dummy length is varied across the volatile field, the non-volatile field, the zero-means-default value and both extremes, 1 and 15. Any miscount then appears either as an early enable or as a byte out of alignment. Rejected opcodes, an aborted read in the dummy phase and a partial-byte abort in the data phase separate a correct reselect flag and bus release from engines that keep state across a deselect.

// File: rtl/dspi_pkg.sv
`timescale 1ns/1ps
// Shared opcodes, command kinds and phase encoding for the dual-line
// flash front-end. Assumes 8-bit opcodes.
package dspi_pkg;
    localparam logic [7:0] OP_FREAD_A = 8'hBB;
    localparam logic [7:0] OP_FREAD_B = 8'h3B;
    localparam logic [7:0] OP_FREAD_C = 8'h0B;
    localparam logic [7:0] OP_MIO_ID  = 8'hAF;

    typedef enum logic [1:0] {
        CMD_NONE  = 2'd0,
        CMD_FREAD = 2'd1,
        CMD_RDID  = 2'd2
    } cmd_e;

    typedef enum logic [2:0] {
        PH_OPC    = 3'd0,
        PH_ADDR   = 3'd1,
        PH_DUMMY  = 3'd2,
        PH_DATA   = 3'd3,
        PH_IGNORE = 3'd4
    } phase_e;
endpackage

// File: rtl/dspi_sclk_edge.sv
`timescale 1ns/1ps
// Finds rising and falling edges of the serial clock by oversampling.
// Assumes sclk is already synchronous to clk and its high and low times
// each last at least two clk periods.
module dspi_sclk_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    output logic rise,
    output logic fall
);
    logic sclk_q;

    // Keeps the previous serial clock level.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_q <= 1'b0;
        else        sclk_q <= sclk;
    end

    assign rise = sclk & ~sclk_q;
    assign fall = ~sclk & sclk_q;
endmodule

// File: rtl/dspi_op_decode.sv
`timescale 1ns/1ps
// Maps an opcode to the command kind this mode supports. Everything that
// is not a dual fast read or the multi-line ID read maps to CMD_NONE.
module dspi_op_decode
    import dspi_pkg::*;
(
    input  logic [7:0] opcode,
    output cmd_e       cmd
);
    // Pure decode of the three fast-read aliases and the ID opcode.
    always_comb begin
        case (opcode)
            OP_FREAD_A, OP_FREAD_B, OP_FREAD_C: cmd = CMD_FREAD;
            OP_MIO_ID:                          cmd = CMD_RDID;
            default:                            cmd = CMD_NONE;
        endcase
    end
endmodule

// File: rtl/dspi_dummy_sel.sv
`timescale 1ns/1ps
// Chooses the dummy clock count from one of two 4-bit configuration
// fields. A zero field means the default count. Assumes DEF_DUMMY >= 1.
module dspi_dummy_sel #(
    parameter int FIELD_W   = 4,
    parameter int DUM_W     = 5,
    parameter int DEF_DUMMY = 8
) (
    input  logic [FIELD_W-1:0] vol_field,
    input  logic [FIELD_W-1:0] nv_field,
    input  logic               src_nv,
    output logic [DUM_W-1:0]   count
);
    logic [FIELD_W-1:0] field;

    // Picks the source field, then substitutes the default for zero.
    always_comb begin
        field = src_nv ? nv_field : vol_field;
        if (field == '0) count = DUM_W'(DEF_DUMMY);
        else             count = DUM_W'(field);
    end
endmodule

// File: rtl/dspi_flash_frontend.sv
`timescale 1ns/1ps
// Target-side protocol engine for the dual-line mode of a serial flash.
// It decodes a 4-clock opcode and collects a 12-clock address. It waits
// out the configured dummy clocks, then streams array bytes or the three
// ID bytes two bits per clock. Assumes cs_n, sclk and dq_i are synchronous
// to clk, and that mem_data follows mem_addr within one clk cycle.
module dspi_flash_frontend
    import dspi_pkg::*;
#(
    parameter int         ADDR_W    = 24,
    parameter int         DEF_DUMMY = 8,
    parameter logic [7:0] ID_BYTE0  = 8'h3C,
    parameter logic [7:0] ID_BYTE1  = 8'hD1,
    parameter logic [7:0] ID_BYTE2  = 8'h19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic [1:0]        dq_i,
    output logic [1:0]        dq_o,
    output logic [1:0]        dq_oe,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [7:0]        mem_data,
    input  logic [7:4]        vol_cfg,
    input  logic [15:12]      nv_cfg,
    input  logic              dummy_src_nv,
    input  logic [4:4]        enh_cfg,
    output logic              hold_en,
    output logic              fast_reselect
);
    localparam int OPC_PAIRS  = 4;
    localparam int ADDR_PAIRS = ADDR_W / 2;
    localparam int DUM_W      = 5;
    localparam int CNT_W      = $clog2(ADDR_PAIRS + (1 << DUM_W));

    logic              sclk_rise, sclk_fall;
    phase_e            phase_q;
    cmd_e              cmd_q, cmd_w;
    logic [CNT_W-1:0]  cnt_q, cnt_nxt;
    logic [5:0]        opc_sr_q;
    logic [7:0]        opcode_w;
    logic [ADDR_W-1:0] addr_q;
    logic [DUM_W-1:0]  dummy_q, dummy_sel;
    logic [1:0]        pair_q, byte_q;
    logic [5:0]        tx_q;
    logic [7:0]        id_byte, src_byte;
    logic              byte_done_q, cs_q;

    dspi_sclk_edge u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .sclk (sclk),
        .rise (sclk_rise),
        .fall (sclk_fall)
    );

    assign opcode_w = {opc_sr_q, dq_i};

    dspi_op_decode u_dec (
        .opcode(opcode_w),
        .cmd   (cmd_w)
    );

    dspi_dummy_sel #(
        .FIELD_W  (4),
        .DUM_W    (DUM_W),
        .DEF_DUMMY(DEF_DUMMY)
    ) u_dsel (
        .vol_field(vol_cfg),
        .nv_field (nv_cfg),
        .src_nv   (dummy_src_nv),
        .count    (dummy_sel)
    );

    assign cnt_nxt  = cnt_q + 1'b1;
    assign mem_addr = addr_q;
    assign hold_en  = ~enh_cfg[4];

    // Selects the identification byte for the current byte slot.
    always_comb begin
        case (byte_q)
            2'd0:    id_byte = ID_BYTE0;
            2'd1:    id_byte = ID_BYTE1;
            default: id_byte = ID_BYTE2;
        endcase
        src_byte = (cmd_q == CMD_RDID) ? id_byte : mem_data;
    end

    // Command sequencer: samples on rising sclk, drives on falling sclk.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q     <= PH_OPC;
            cmd_q       <= CMD_NONE;
            cnt_q       <= '0;
            opc_sr_q    <= '0;
            addr_q      <= '0;
            dummy_q     <= DUM_W'(DEF_DUMMY);
            pair_q      <= '0;
            byte_q      <= '0;
            tx_q        <= '0;
            dq_o        <= '0;
            dq_oe       <= '0;
            byte_done_q <= 1'b0;
        end else if (cs_n) begin
            phase_q     <= PH_OPC;
            cmd_q       <= CMD_NONE;
            cnt_q       <= '0;
            pair_q      <= '0;
            byte_q      <= '0;
            dq_oe       <= '0;
            byte_done_q <= 1'b0;
        end else if (sclk_rise) begin
            case (phase_q)
                PH_OPC: begin
                    opc_sr_q <= {opc_sr_q[3:0], dq_i};
                    if (cnt_q == CNT_W'(OPC_PAIRS - 1)) begin
                        cnt_q   <= '0;
                        cmd_q   <= cmd_w;
                        dummy_q <= dummy_sel;
                        case (cmd_w)
                            CMD_FREAD: phase_q <= PH_ADDR;
                            CMD_RDID:  phase_q <= PH_DATA;
                            default:   phase_q <= PH_IGNORE;
                        endcase
                    end else begin
                        cnt_q <= cnt_nxt;
                    end
                end
                PH_ADDR: begin
                    addr_q <= {addr_q[ADDR_W-3:0], dq_i};
                    if (cnt_q == CNT_W'(ADDR_PAIRS - 1)) begin
                        cnt_q   <= '0;
                        phase_q <= PH_DUMMY;
                    end else begin
                        cnt_q <= cnt_nxt;
                    end
                end
                PH_DUMMY: begin
                    if (cnt_nxt == CNT_W'(dummy_q)) begin
                        cnt_q   <= '0;
                        phase_q <= PH_DATA;
                    end else begin
                        cnt_q <= cnt_nxt;
                    end
                end
                default: ;
            endcase
        end else if (sclk_fall && phase_q == PH_DATA) begin
            if (cmd_q == CMD_RDID && byte_q == 2'd3) begin
                dq_oe <= 2'b00;
            end else begin
                dq_oe <= 2'b11;
                if (pair_q == 2'd0) begin
                    dq_o <= src_byte[7:6];
                    tx_q <= src_byte[5:0];
                end else begin
                    dq_o <= tx_q[5:4];
                    tx_q <= {tx_q[3:0], 2'b00};
                end
                pair_q <= pair_q + 1'b1;
                if (pair_q == 2'd3) begin
                    byte_done_q <= 1'b1;
                    if (cmd_q == CMD_RDID) byte_q <= byte_q + 1'b1;
                    else                   addr_q <= addr_q + 1'b1;
                end
            end
        end
    end

    // Records on each deselect whether the select ended after a full read byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_q          <= 1'b1;
            fast_reselect <= 1'b0;
        end else begin
            cs_q <= cs_n;
            if (cs_n && !cs_q) fast_reselect <= byte_done_q;
        end
    end
endmodule

// File: rtl/dspi_flash_frontend_chk.sv
`timescale 1ns/1ps
// Port-level protocol checks for the dual-line front-end, bound to it.
// Assumes the same clock and synchronous reset as the design.
module dspi_flash_frontend_chk #(
    parameter int ADDR_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n,
    input logic              sclk,
    input logic [1:0]        dq_o,
    input logic [1:0]        dq_oe,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              fast_reselect
);
    // R9
    bus_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> (dq_oe == 2'b00));

    // R5
    oe_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dq_oe == 2'b00) || (dq_oe == 2'b11));

    // R5
    oe_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(sclk) |=> !$rose(dq_oe[0]));

    // R1
    dq_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(sclk) |=> $stable(dq_o));

    // R6
    addr_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$fell(sclk) && !$rose(sclk)) |=> $stable(mem_addr));

    // R10
    flag_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(cs_n) |=> $stable(fast_reselect));
endmodule

bind dspi_flash_frontend dspi_flash_frontend_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .cs_n         (cs_n),
    .sclk         (sclk),
    .dq_o         (dq_o),
    .dq_oe        (dq_oe),
    .mem_addr     (mem_addr),
    .fast_reselect(fast_reselect)
);

// File: tb/dspi_flash_frontend_tb_top.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario, each checking its own results.
module dspi_flash_frontend_tb_top;
    localparam logic [7:0] TB_ID0 = 8'h4E;
    localparam logic [7:0] TB_ID1 = 8'hA3;
    localparam logic [7:0] TB_ID2 = 8'h17;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        sclk = 1'b0;
    logic [1:0]  dq_i = 2'b00;
    logic [1:0]  dq_o, dq_oe;
    logic [23:0] mem_addr;
    logic [7:0]  mem_data;
    logic [7:4]  vol_cfg = 4'h0;
    logic [15:12] nv_cfg = 4'h0;
    logic        dummy_src_nv = 1'b0;
    logic [4:4]  enh_cfg = 1'b0;
    logic        hold_en, fast_reselect;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    function automatic logic [7:0] exp_mem(input logic [23:0] a);
        return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'hA5;
    endfunction

    assign mem_data = exp_mem(mem_addr);

    dspi_flash_frontend #(
        .ADDR_W(24), .DEF_DUMMY(8),
        .ID_BYTE0(TB_ID0), .ID_BYTE1(TB_ID1), .ID_BYTE2(TB_ID2)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk),
        .dq_i(dq_i), .dq_o(dq_o), .dq_oe(dq_oe),
        .mem_addr(mem_addr), .mem_data(mem_data),
        .vol_cfg(vol_cfg), .nv_cfg(nv_cfg), .dummy_src_nv(dummy_src_nv),
        .enh_cfg(enh_cfg), .hold_en(hold_en), .fast_reselect(fast_reselect)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_sim();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    // One serial clock: sample outputs before the rise, then pulse sclk.
    task automatic sclk_cycle(input logic [1:0] din, output logic [1:0] dout,
                              output logic [1:0] oe);
        dq_i = din;
        repeat (2) @(negedge clk);
        dout = dq_o;
        oe   = dq_oe;
        sclk = 1'b1;
        repeat (4) @(negedge clk);
        sclk = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] b, inout logic oe_any);
        logic [1:0] d, o;
        for (int i = 3; i >= 0; i--) begin
            sclk_cycle(b[2*i +: 2], d, o);
            oe_any |= (o != 2'b00);
        end
    endtask

    task automatic send_addr(input logic [23:0] a, inout logic oe_any);
        logic [1:0] d, o;
        for (int i = 11; i >= 0; i--) begin
            sclk_cycle(a[2*i +: 2], d, o);
            oe_any |= (o != 2'b00);
        end
    endtask

    task automatic read_byte(output logic [7:0] b, output logic oe_all, output logic oe_none);
        logic [1:0] d, o;
        b = '0; oe_all = 1'b1; oe_none = 1'b1;
        for (int i = 0; i < 4; i++) begin
            sclk_cycle(2'b00, d, o);
            b = {b[5:0], d};
            oe_all  &= (o == 2'b11);
            oe_none &= (o == 2'b00);
        end
    endtask

    task automatic select();
        cs_n = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic deselect(input string req);
        cs_n = 1'b1;
        repeat (2) @(negedge clk);
        check(dq_oe == 2'b00, "R9", {req, " lines released on deselect"}, dq_oe, 0);
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        check(dq_oe == 2'b00, "R5", "reset oe", dq_oe, 0);
        check(fast_reselect == 1'b0, "R10", "reset flag", fast_reselect, 0);
        check(hold_en == 1'b1, "R11", "reset hold enable", hold_en, 1);
    endtask

    // R1 R2 R3 R4 R5 R6: full dual fast read with a given dummy source.
    task automatic t_fast_read(input logic [7:0] op, input logic [23:0] a,
                               input int nbytes, input logic nv_src,
                               input logic [3:0] vf, input logic [3:0] nf,
                               input int exp_dummy, input string req);
        logic oe_any;
        logic [1:0] d, o;
        logic [7:0] b;
        logic oe_all, oe_none;
        vol_cfg = vf; nv_cfg = nf; dummy_src_nv = nv_src;
        select();
        oe_any = 1'b0;
        send_byte(op, oe_any);
        send_addr(a, oe_any);
        for (int i = 0; i < exp_dummy; i++) begin
            sclk_cycle(2'b00, d, o);
            oe_any |= (o != 2'b00);
        end
        check(!oe_any, "R5", {req, " idle lines before data"}, oe_any, 0);
        for (int i = 0; i < nbytes; i++) begin
            read_byte(b, oe_all, oe_none);
            check(b == exp_mem(a + 24'(i)), "R6", {req, " data byte"}, b, exp_mem(a + 24'(i)));
            check(oe_all, "R5", {req, " lines driven in data"}, oe_all, 1);
        end
        deselect(req);
        check(fast_reselect == 1'b1, "R10", {req, " flag after read"}, fast_reselect, 1);
    endtask

    // R7: multi-line ID read returns three bytes, then releases.
    task automatic t_read_id();
        logic oe_any;
        logic [7:0] b;
        logic oe_all, oe_none;
        logic [7:0] exp_id [3];
        exp_id[0] = TB_ID0; exp_id[1] = TB_ID1; exp_id[2] = TB_ID2;
        select();
        oe_any = 1'b0;
        send_byte(8'hAF, oe_any);
        check(!oe_any, "R5", "id opcode phase idle", oe_any, 0);
        for (int i = 0; i < 3; i++) begin
            read_byte(b, oe_all, oe_none);
            check(b == exp_id[i], "R7", "id byte", b, exp_id[i]);
            check(oe_all, "R7", "id lines driven", oe_all, 1);
        end
        for (int i = 0; i < 2; i++) begin
            read_byte(b, oe_all, oe_none);
            check(oe_none, "R7", "lines released after three id bytes", oe_none, 1);
        end
        deselect("R7");
        check(fast_reselect == 1'b1, "R10", "flag after id read", fast_reselect, 1);
    endtask

    // R8: unsupported opcode never drives the lines.
    task automatic t_reject(input logic [7:0] op);
        logic oe_any;
        logic [1:0] d, o;
        vol_cfg = 4'h1; dummy_src_nv = 1'b0;
        select();
        oe_any = 1'b0;
        send_byte(op, oe_any);
        for (int i = 0; i < 24; i++) begin
            sclk_cycle(2'b01, d, o);
            oe_any |= (o != 2'b00);
        end
        check(!oe_any, "R8", "unsupported opcode left lines idle", op, 0);
        deselect("R8");
        check(fast_reselect == 1'b0, "R10", "flag after rejected opcode", fast_reselect, 0);
    endtask

    // R9 R10: aborts in the dummy and data phases, then a clean command.
    task automatic t_abort();
        logic oe_any;
        logic [1:0] d, o;
        vol_cfg = 4'h0; dummy_src_nv = 1'b0;
        select();
        oe_any = 1'b0;
        send_byte(8'hBB, oe_any);
        send_addr(24'h00F0F0, oe_any);
        sclk_cycle(2'b00, d, o);
        deselect("R9 dummy abort");
        check(fast_reselect == 1'b0, "R10", "flag after dummy abort", fast_reselect, 0);
        select();
        send_byte(8'h3B, oe_any);
        send_addr(24'h00F0F0, oe_any);
        for (int i = 0; i < 8; i++) sclk_cycle(2'b00, d, o);
        sclk_cycle(2'b00, d, o);
        check(o == 2'b11, "R5", "partial read drives", o, 2'b11);
        deselect("R9 data abort");
        check(fast_reselect == 1'b0, "R10", "flag after partial byte", fast_reselect, 0);
        t_fast_read(8'h0B, 24'h5A5A5A, 1, 1'b0, 4'h2, 4'h0, 2, "R9 restart");
    endtask

    // R11: hold enable follows enhanced configuration bit 4.
    task automatic t_hold();
        enh_cfg = 1'b1;
        repeat (2) @(negedge clk);
        check(hold_en == 1'b0, "R11", "hold disabled", hold_en, 0);
        enh_cfg = 1'b0;
        repeat (2) @(negedge clk);
        check(hold_en == 1'b1, "R11", "hold enabled", hold_en, 1);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_reset();
        t_fast_read(8'hBB, 24'h123456, 3, 1'b0, 4'h5, 4'h9, 5, "R2 BB R3 vol");
        t_fast_read(8'h3B, 24'hC0FFEE, 2, 1'b1, 4'h9, 4'h3, 3, "R2 3B R3 nv");
        t_fast_read(8'h0B, 24'h0A0B0C, 2, 1'b0, 4'h0, 4'h6, 8, "R2 0B R4 default");
        t_fast_read(8'hBB, 24'hFFFFFE, 3, 1'b1, 4'h3, 4'hF, 15, "R4 max R6 wrap");
        t_fast_read(8'h3B, 24'h8421C3, 2, 1'b0, 4'h1, 4'h0, 1, "R4 min R1 order");
        t_read_id();
        t_reject(8'h03);
        t_fast_read(8'hBB, 24'h000100, 1, 1'b0, 4'h4, 4'h0, 4, "R10 set");
        t_reject(8'h6B);
        t_reject(8'hEB);
        t_reject(8'h02);
        t_reject(8'h9F);
        t_abort();
        t_hold();
        finish_sim();
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL R9 watchdog actual=timeout expected=done");
        finish_sim();
    end
endmodule